// File: doc/BRIEF.md
# Packed Four-Lane Single-Precision Maximum

This unit takes two 128-bit operands, each holding four IEEE-754 single-precision values, and returns, lane by lane, the larger of each pair in a 128-bit result. The first operand is also the destination. The output therefore replaces the first source, or, when an unmasked invalid operation occurs, is left equal to it.

Selection is not symmetric. When both values of a lane are zeros, or when either is a NaN, the lane takes the second operand's value as it is. A NaN on any input raises an invalid flag. If invalid exceptions are unmasked, the unit also raises an exception output and does not write the result.

Operands are taken on a start strobe. The result and flags appear one clock later, together with a one-cycle done pulse, and then stay put until the next strobe.

Top module: `pmax4`

## Requirements
- R1: Each 32-bit lane (bits 31:0, 63:32, 95:64, 127:96) is computed only from the same lane of both operands and is written to the same lane of the result.
- R2: For ordinary values the lane result is the numerically greater input. A positive value beats a negative one. Between two positives the larger magnitude wins, and between two negatives the smaller magnitude wins. Denormals compare by exact value, and infinities are the extremes of their sign.
- R3: When both lane inputs are zero (exponent and fraction all 0), whatever their signs, the lane result is the second operand's lane value bit for bit.
- R4: When either lane input is a NaN (exponent all ones, fraction nonzero; quiet or signalling) and inv_mask was high at start, the lane result is the second operand's lane value, and exc stays low.
- R5: invalid is high after an operation exactly when at least one lane of either operand held a NaN.
- R6: When a NaN is present and inv_mask was low, exc is high and the whole result equals the first operand, leaving the destination unmodified.
- R7: done is high exactly in the cycle after a start. result, invalid and exc change only then, and they hold while start is low.
- R8: A synchronous active-high rst clears result, done, invalid and exc to zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Capture operands and compute |
| src_a | input | 128 | First source and destination value |
| src_b | input | 128 | Second source |
| inv_mask | input | 1 | High masks the invalid-operation exception |
| result | output | 128 | Registered destination value |
| done | output | 1 | One-cycle pulse, result valid |
| invalid | output | 1 | Some lane held a NaN input |
| exc | output | 1 | Unmasked invalid-operation exception |

## Verification
The assertions assume that start, the operands and inv_mask are steady around the rising edge, so that $past of the operands in a done cycle is what the unit captured. They also assume the unit comes out of reset before start is used. The bench drives every input on the falling edge and raises rst only between operations, which satisfies both. The random operand generator is weighted so that signed zeros, both NaN kinds, infinities, denormals and operand pairs equal in magnitude all appear alongside normal values.

// File: rtl/pmax4.sv
module pmax4 #(
  parameter int LANES = 4,
  parameter int EW    = 8,
  parameter int FW    = 23
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       start,
  input  logic [LANES*(1+EW+FW)-1:0] src_a,
  input  logic [LANES*(1+EW+FW)-1:0] src_b,
  input  logic                       inv_mask,
  output logic [LANES*(1+EW+FW)-1:0] result,
  output logic                       done,
  output logic                       invalid,
  output logic                       exc
);
  localparam int LW = 1 + EW + FW;
  localparam int DW = LANES * LW;

  logic [DW-1:0]    max_vec;
  logic [LANES-1:0] nan_lane;

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    logic [LW-1:0] a, b;
    logic a_nan, b_nan, both_zero, a_gt;
    assign a = src_a[i*LW +: LW];
    assign b = src_b[i*LW +: LW];
    assign a_nan = (&a[LW-2:FW]) && (|a[FW-1:0]);
    assign b_nan = (&b[LW-2:FW]) && (|b[FW-1:0]);
    assign both_zero = ~|{a[LW-2:0], b[LW-2:0]};
    always_comb begin
      if (a[LW-1] != b[LW-1]) a_gt = ~a[LW-1];
      else if (!a[LW-1])      a_gt = a[LW-2:0] > b[LW-2:0];
      else                    a_gt = a[LW-2:0] < b[LW-2:0];
    end
    assign nan_lane[i] = a_nan | b_nan;
    assign max_vec[i*LW +: LW] = (!nan_lane[i] && !both_zero && a_gt) ? a : b;
  end

  logic any_nan, trap;
  assign any_nan = |nan_lane;
  assign trap    = any_nan & ~inv_mask;

  always_ff @(posedge clk) begin
    if (rst) begin
      result  <= '0;
      done    <= 1'b0;
      invalid <= 1'b0;
      exc     <= 1'b0;
    end else begin
      done <= start;
      if (start) begin
        invalid <= any_nan;
        exc     <= trap;
        result  <= trap ? src_a : max_vec;
      end
    end
  end
endmodule

module pmax4_chk #(
  parameter int DW = 128
) (
  input logic          clk,
  input logic          rst,
  input logic          start,
  input logic [DW-1:0] src_a,
  input logic [DW-1:0] src_b,
  input logic          inv_mask,
  input logic [DW-1:0] result,
  input logic          done,
  input logic          invalid,
  input logic          exc
);
  logic rst_q;
  always_ff @(posedge clk) rst_q <= rst;

  always @(posedge clk)
    if (rst_q == 1'b1)
      AST_RESET_CLEAR: assert (result == '0 && !done && !invalid && !exc); // R8

  AST_DONE_AFTER_START: assert property (@(posedge clk) disable iff (rst)
    start |=> done); // R7
  AST_NO_SPURIOUS_DONE: assert property (@(posedge clk) disable iff (rst)
    !start |=> !done); // R7
  AST_RESULT_HOLDS: assert property (@(posedge clk) disable iff (rst)
    !start |=> ($stable(result) && $stable(invalid) && $stable(exc))); // R7
  AST_EXC_NEEDS_INVALID: assert property (@(posedge clk) disable iff (rst)
    exc |-> invalid); // R6
  AST_EXC_KEEPS_DEST: assert property (@(posedge clk) disable iff (rst)
    start && !inv_mask ##1 done && exc |-> result == $past(src_a)); // R6
  AST_MASKED_NO_EXC: assert property (@(posedge clk) disable iff (rst)
    start && inv_mask |=> !exc); // R4
  AST_EQUAL_OPERANDS: assert property (@(posedge clk) disable iff (rst)
    start && (src_a == src_b) |=> result == $past(src_b)); // R1
endmodule

bind pmax4 pmax4_chk #(.DW(DW)) u_chk (.*);

// File: tb/tb_pmax4.sv
module tb_pmax4;
  localparam int CLK_PERIOD = 10;

  logic         clk = 1'b0;
  logic         rst, start, inv_mask;
  logic [127:0] src_a, src_b;
  logic [127:0] result;
  logic         done, invalid, exc;
  int checks = 0, errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pmax4 dut (.clk(clk), .rst(rst), .start(start), .src_a(src_a), .src_b(src_b),
             .inv_mask(inv_mask), .result(result), .done(done),
             .invalid(invalid), .exc(exc));

  function automatic bit is_nan(input logic [31:0] x);
    return x[30:23] == 8'hFF && x[22:0] != 0;
  endfunction

  function automatic logic [31:0] key(input logic [31:0] x);
    return x[31] ? ~x : {1'b1, x[30:0]};
  endfunction

  function automatic logic [31:0] ref_lane(input logic [31:0] a, input logic [31:0] b);
    if (is_nan(a) || is_nan(b)) return b;
    if (a[30:0] == 0 && b[30:0] == 0) return b;
    return (key(a) > key(b)) ? a : b;
  endfunction

  function automatic logic [31:0] rnd_lane();
    logic [31:0] r = $urandom;
    case ($urandom % 9)
      0: return 32'h0000_0000;
      1: return 32'h8000_0000;
      2: return {r[31], 8'hFF, 1'b1, r[21:0]};
      3: return {r[31], 8'hFF, 1'b0, r[21:1], 1'b1};
      4: return {r[31], 8'hFF, 23'h0};
      5: return {r[31], 8'h00, r[22:0]};
      default: return r;
    endcase
  endfunction

  task automatic check(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic run_op(input logic [127:0] a, input logic [127:0] b, input bit m, input string tag);
    logic [127:0] exp_r;
    bit nan = 0;
    logic [127:0] prev;
    for (int i = 0; i < 4; i++) begin
      exp_r[i*32 +: 32] = ref_lane(a[i*32 +: 32], b[i*32 +: 32]);
      nan |= is_nan(a[i*32 +: 32]) | is_nan(b[i*32 +: 32]);
    end
    if (nan && !m) exp_r = a;
    src_a = a; src_b = b; inv_mask = m; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(done === 1'b1, "R7 done", {127'd0, done}, 128'd1);
    check(result === exp_r, tag, result, exp_r);
    check(invalid === nan, "R5 invalid", {127'd0, invalid}, {127'd0, nan});
    check(exc === (nan && !m), "R6 exc", {127'd0, exc}, {127'd0, nan && !m});
    prev = result;
    src_a = ~a; src_b = ~b;
    @(negedge clk);
    check(done === 1'b0 && result === prev, "R7 hold", result, prev);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog expired actual running expected finished");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    rst = 1'b1; start = 1'b0; inv_mask = 1'b1; src_a = '0; src_b = '0;
    repeat (3) @(negedge clk);
    check(result === '0 && !done && !invalid && !exc, "R8 reset", result, '0);
    rst = 1'b0;
    @(negedge clk);

    run_op({32'h3F80_0000, 32'hBF80_0000, 32'h4000_0000, 32'hC000_0000},
           {32'hBF80_0000, 32'h3F80_0000, 32'h3F80_0000, 32'hBF80_0000}, 1, "R2 sign/mag");
    run_op({32'h0000_0001, 32'h8000_0001, 32'h7F80_0000, 32'hFF80_0000},
           {32'h0000_0002, 32'h8000_0002, 32'h7F7F_FFFF, 32'hFF7F_FFFF}, 1, "R2 denorm/inf");
    run_op({32'h0000_0000, 32'h8000_0000, 32'h0000_0000, 32'h8000_0000},
           {32'h8000_0000, 32'h0000_0000, 32'h0000_0000, 32'h8000_0000}, 1, "R3 zeros");
    run_op({32'h7FC0_0000, 32'h4120_0000, 32'h7F80_0001, 32'h1234_5678},
           {32'h3F80_0000, 32'hFFC0_0001, 32'hC000_0000, 32'h0000_0000}, 1, "R4 masked nan");
    run_op({32'h3F80_0000, 32'h4000_0000, 32'h7F80_0001, 32'h1234_5678},
           {32'h4040_0000, 32'h3F80_0000, 32'hC000_0000, 32'h0000_0000}, 0, "R6 unmasked nan");
    run_op({32'h4000_0000, 32'h3F80_0000, 32'hC000_0000, 32'h0000_0000},
           {32'h3F80_0000, 32'h4000_0000, 32'h3F80_0000, 32'h8000_0000}, 0, "R1 lanes no nan");

    for (int n = 0; n < 400; n++) begin
      logic [127:0] a, b;
      for (int i = 0; i < 4; i++) begin
        a[i*32 +: 32] = rnd_lane();
        case ($urandom % 6)
          0: b[i*32 +: 32] = a[i*32 +: 32];
          1: b[i*32 +: 32] = a[i*32 +: 32] ^ 32'h8000_0000;
          default: b[i*32 +: 32] = rnd_lane();
        endcase
      end
      run_op(a, b, 1'($urandom % 4 != 0), "R1 R2 random");
    end

    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check(result === '0 && !done && !invalid && !exc, "R8 reset after use", result, '0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule